// File: doc/BRIEF.md
# TLB Exception Entry Controller

This block performs exception entry for address-translation faults on a 32-bit processor. Each cycle it samples fault flags from the instruction-fetch side (miss, invalid descriptor, protection violation, guarded fetch) and from the data-access side (miss), together with the current machine-state word and the effective address of the faulting instruction. When a fault is enabled by its translation-enable bit, one exception class is chosen. The block then registers the saved address, the saved status word and the new machine-state word, and pulses a redirect for one clock with the target fetch address.

Bits are numbered big-endian: bit 0 is the most significant bit of a 32-bit word, so big-endian bit k is vector index 31-k. The machine-state bits used here sit at these big-endian positions: instruction-little-endian 15, machine-check-enable 19, interrupt-prefix 25, instruction relocation 26, data relocation 27 and little-endian 31. In vector terms these are indices 16, 12, 6, 5, 4 and 0.

The target address is the exception base plus the class offset. The base is 0x00000000 when the interrupt-prefix bit is clear and 0xFFF00000 when it is set. In the cycle right after an entry, incoming faults are ignored, because they belong to instructions that the redirect squashes.

Top module: `tlb_exc_entry`

## Requirements
- R1: After synchronous reset, every output is zero and the redirect is low.
- R2: An instruction miss uses offset 0x1100, an instruction error uses offset 0x1300 and a data miss uses offset 0x1200. The redirect target is the base plus the offset and appears in the cycle after the fault.
- R3: The base is 0x00000000 when the interrupt-prefix bit (index 6) of the current state is 0, and 0xFFF00000 when it is 1.
- R4: Instruction faults are taken only when instruction relocation (index 5) is 1, and data misses only when data relocation (index 4) is 1. A fault whose enable is clear raises no redirect and changes no output.
- R5: When several faults are enabled in one cycle, an instruction miss wins over an instruction error, and an instruction error wins over a data miss.
- R6: Save register 0 receives the effective address presented with the fault.
- R7: Save status big-endian bits 0–15 (indices 31..16) depend on the class. For an instruction miss, only bit 4 (index 27) is set. For a data miss, all of them are clear. For an instruction error, bit 1 (index 30) equals the invalid flag, bit 3 (index 28) equals the guarded flag, bit 4 (index 27) equals the protection flag, and all others are clear.
- R8: Save status big-endian bits 16–31 (indices 15..0) are copied from the current machine-state word.
- R9: In the new machine state, interrupt-prefix (index 6) and machine-check-enable (index 12) keep their values, and little-endian (index 0) takes the value of instruction-little-endian (index 16). Every other bit is 0.
- R10: The redirect lasts exactly one clock. Faults in the cycle right after an entry are ignored, and a fault in the cycle after that is taken.
- R11: Without an entry, the save registers, the machine-state output and the target hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msr_i | input | 32 | Current machine-state word |
| ea_i | input | 32 | Effective address of the faulting instruction |
| imiss_i | input | 1 | Instruction translation miss |
| dmiss_i | input | 1 | Data translation miss |
| inval_i | input | 1 | Fetch descriptor has segment or page valid clear |
| prot_i | input | 1 | Fetch violates memory protection |
| guard_i | input | 1 | Fetch targets guarded memory |
| srr0_o | output | 32 | Saved effective address |
| srr1_o | output | 32 | Saved status word |
| msr_o | output | 32 | New machine-state word |
| redir_o | output | 1 | One-cycle redirect pulse |
| target_o | output | 32 | Redirect fetch address |

## Verification
A wrong class choice shows up one cycle after the fault. The target offset is wrong in that cycle, and so is the upper half of the saved status. A broken blackout flag shows up when faults arrive back to back: the redirect either stays high for two cycles or misses the third fault. An error in gating or in the hold logic shows up as a redirect, or as a changed saved value, in the cycle after an ignored fault. The bench checks that cycle every time.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int XLEN = 32;
  // little-endian vector indices of big-endian state bit positions
  localparam int IX_LE  = XLEN - 1 - 31;
  localparam int IX_DR  = XLEN - 1 - 27;
  localparam int IX_IR  = XLEN - 1 - 26;
  localparam int IX_IP  = XLEN - 1 - 25;
  localparam int IX_ME  = XLEN - 1 - 19;
  localparam int IX_ILE = XLEN - 1 - 15;
  localparam int HALF   = XLEN / 2;

  typedef enum logic [1:0] {FK_NONE, FK_IMISS, FK_IERR, FK_DMISS} fault_kind_e;

  typedef struct packed {
    logic imiss;
    logic dmiss;
    logic inval;
    logic prot;
    logic guard;
  } fault_flags_t;
endpackage

// File: rtl/tlbx_arbiter.sv
module tlbx_arbiter
  import tlbx_pkg::*;
(
  input  logic         ir_en,
  input  logic         dr_en,
  input  logic         blank,
  input  fault_flags_t flags,
  output fault_kind_e  kind
);
  logic ierr_any;
  assign ierr_any = flags.inval | flags.prot | flags.guard;

  always_comb begin
    kind = FK_NONE;
    if (!blank) begin
      if (ir_en && flags.imiss)     kind = FK_IMISS;
      else if (ir_en && ierr_any)   kind = FK_IERR;
      else if (dr_en && flags.dmiss) kind = FK_DMISS;
    end
  end
endmodule

// File: rtl/tlbx_status_builder.sv
module tlbx_status_builder
  import tlbx_pkg::*;
(
  input  fault_kind_e       kind,
  input  logic              inval,
  input  logic              prot,
  input  logic              guard,
  input  logic [HALF-1:0]   msr_lo,
  output logic [XLEN-1:0]   srr1
);
  // code is indexed big-endian: code[0] lands in the word's MSB
  logic [0:HALF-1] code;

  always_comb begin
    code = '0;
    case (kind)
      FK_IMISS: code[4] = 1'b1;
      FK_IERR: begin
        code[1] = inval;
        code[3] = guard;
        code[4] = prot;
      end
      default: code = '0;
    endcase
  end

  assign srr1 = {code, msr_lo};
endmodule

// File: rtl/tlbx_state_builder.sv
module tlbx_state_builder
  import tlbx_pkg::*;
#(
  parameter logic [XLEN-1:0] BASE_LO   = 32'h0000_0000,
  parameter logic [XLEN-1:0] BASE_HI   = 32'hFFF0_0000,
  parameter logic [XLEN-1:0] OFF_IMISS = 32'h0000_1100,
  parameter logic [XLEN-1:0] OFF_DMISS = 32'h0000_1200,
  parameter logic [XLEN-1:0] OFF_IERR  = 32'h0000_1300
) (
  input  fault_kind_e      kind,
  input  logic             ip,
  input  logic             me,
  input  logic             ile,
  output logic [XLEN-1:0]  new_msr,
  output logic [XLEN-1:0]  target
);
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    if (i == IX_IP) begin : g_ip
      assign new_msr[i] = ip;
    end else if (i == IX_ME) begin : g_me
      assign new_msr[i] = me;
    end else if (i == IX_LE) begin : g_le
      assign new_msr[i] = ile;
    end else begin : g_zero
      assign new_msr[i] = 1'b0;
    end
  end

  logic [XLEN-1:0] base, offset;
  assign base = ip ? BASE_HI : BASE_LO;

  always_comb begin
    case (kind)
      FK_IMISS: offset = OFF_IMISS;
      FK_IERR:  offset = OFF_IERR;
      FK_DMISS: offset = OFF_DMISS;
      default:  offset = '0;
    endcase
  end

  assign target = base + offset;
endmodule

// File: rtl/tlb_exc_entry.sv
module tlb_exc_entry
  import tlbx_pkg::*;
#(
  parameter logic [31:0] BASE_LO   = 32'h0000_0000,
  parameter logic [31:0] BASE_HI   = 32'hFFF0_0000,
  parameter logic [31:0] OFF_IMISS = 32'h0000_1100,
  parameter logic [31:0] OFF_DMISS = 32'h0000_1200,
  parameter logic [31:0] OFF_IERR  = 32'h0000_1300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] msr_i,
  input  logic [31:0] ea_i,
  input  logic        imiss_i,
  input  logic        dmiss_i,
  input  logic        inval_i,
  input  logic        prot_i,
  input  logic        guard_i,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] msr_o,
  output logic        redir_o,
  output logic [31:0] target_o
);
  fault_flags_t    flags;
  fault_kind_e     kind;
  logic [XLEN-1:0] srr1_nx, msr_nx, target_nx;

  assign flags = '{imiss: imiss_i, dmiss: dmiss_i, inval: inval_i,
                   prot: prot_i, guard: guard_i};

  tlbx_arbiter u_arb (
    .ir_en (msr_i[IX_IR]),
    .dr_en (msr_i[IX_DR]),
    .blank (redir_o),
    .flags (flags),
    .kind  (kind)
  );

  tlbx_status_builder u_stat (
    .kind   (kind),
    .inval  (inval_i),
    .prot   (prot_i),
    .guard  (guard_i),
    .msr_lo (msr_i[HALF-1:0]),
    .srr1   (srr1_nx)
  );

  tlbx_state_builder #(
    .BASE_LO  (BASE_LO),
    .BASE_HI  (BASE_HI),
    .OFF_IMISS(OFF_IMISS),
    .OFF_DMISS(OFF_DMISS),
    .OFF_IERR (OFF_IERR)
  ) u_state (
    .kind    (kind),
    .ip      (msr_i[IX_IP]),
    .me      (msr_i[IX_ME]),
    .ile     (msr_i[IX_ILE]),
    .new_msr (msr_nx),
    .target  (target_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      srr0_o   <= '0;
      srr1_o   <= '0;
      msr_o    <= '0;
      redir_o  <= 1'b0;
      target_o <= '0;
    end else begin
      redir_o <= (kind != FK_NONE);
      if (kind != FK_NONE) begin
        srr0_o   <= ea_i;
        srr1_o   <= srr1_nx;
        msr_o    <= msr_nx;
        target_o <= target_nx;
      end
    end
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    redir_o |=> !redir_o); // R10
  AST_NO_EN_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (!msr_i[IX_IR] && !msr_i[IX_DR]) |=> !redir_o); // R4
  AST_SRR0_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    redir_o |-> srr0_o == $past(ea_i)); // R6
  AST_SRR1_COPY: assert property (@(posedge clk) disable iff (rst)
    redir_o |-> srr1_o[HALF-1:0] == $past(msr_i[HALF-1:0])); // R8
  AST_PREFIX_KEEP: assert property (@(posedge clk) disable iff (rst)
    redir_o |-> (msr_o[IX_IP] == $past(msr_i[IX_IP]) &&
                 msr_o[IX_LE] == $past(msr_i[IX_ILE]))); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!redir_o && !$past(rst)) |-> ($stable(srr0_o) && $stable(target_o))); // R11
endmodule

// File: tb/tlb_exc_entry_tb.sv
module tlb_exc_entry_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] msr_i = '0, ea_i = '0;
  logic        imiss_i = 0, dmiss_i = 0, inval_i = 0, prot_i = 0, guard_i = 0;
  logic [31:0] srr0_o, srr1_o, msr_o, target_o;
  logic        redir_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_exc_entry u_dut (
    .clk(clk), .rst(rst), .msr_i(msr_i), .ea_i(ea_i),
    .imiss_i(imiss_i), .dmiss_i(dmiss_i), .inval_i(inval_i),
    .prot_i(prot_i), .guard_i(guard_i),
    .srr0_o(srr0_o), .srr1_o(srr1_o), .msr_o(msr_o),
    .redir_o(redir_o), .target_o(target_o)
  );

  // kind: 0 none, 1 imiss, 2 ierr, 3 dmiss; flags {imiss,dmiss,inval,prot,guard}
  typedef struct packed {
    logic [31:0] msr;
    logic [4:0]  flg;
    logic [1:0]  kind;
    logic [31:0] tgt;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0030, 5'b10000, 2'd1, 32'h0000_1100, 8'd2},
    '{32'h0001_1070, 5'b01000, 2'd3, 32'hFFF0_1200, 8'd3},
    '{32'h0000_0020, 5'b01000, 2'd0, 32'h0,         8'd4},
    '{32'h0000_0010, 5'b10000, 2'd0, 32'h0,         8'd4},
    '{32'h0000_0010, 5'b00100, 2'd0, 32'h0,         8'd4},
    '{32'hFFFF_FFFF, 5'b11001, 2'd1, 32'hFFF0_1100, 8'd5},
    '{32'h0000_0060, 5'b01011, 2'd2, 32'hFFF0_1300, 8'd3},
    '{32'h0000_0030, 5'b01100, 2'd2, 32'h0000_1300, 8'd5},
    '{32'h0000_0010, 5'b11000, 2'd3, 32'h0000_1200, 8'd5},
    '{32'h5A5A_C3B1, 5'b00010, 2'd2, 32'h0000_1300, 8'd7},
    '{32'h0000_0000, 5'b00000, 2'd0, 32'h0,         8'd11}
  };

  logic [31:0] e_srr0 = 0, e_srr1 = 0, e_msr = 0, e_tgt = 0;

  function automatic logic [31:0] m_srr1(logic [1:0] k, logic [31:0] m, logic [4:0] f);
    logic [31:0] r;
    r = {16'h0, m[15:0]};
    if (k == 2'd1) r[27] = 1'b1;
    if (k == 2'd2) begin r[30] = f[2]; r[28] = f[0]; r[27] = f[1]; end
    return r;
  endfunction

  function automatic logic [31:0] m_msr(logic [31:0] m);
    logic [31:0] r;
    r = '0;
    r[6] = m[6]; r[12] = m[12]; r[0] = m[16];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] m, logic [31:0] ea, logic [4:0] f);
    msr_i = m; ea_i = ea;
    {imiss_i, dmiss_i, inval_i, prot_i, guard_i} = f;
  endtask

  task automatic chk_all(string req, logic exp_r);
    chk(req, {31'h0, redir_o}, {31'h0, exp_r}, "redir");
    chk(req, srr0_o, e_srr0, "srr0");
    chk(req, srr1_o, e_srr1, "srr1");
    chk(req, msr_o, e_msr, "msr");
    chk(req, target_o, e_tgt, "target");
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rst = 1'b0;
    chk_all("R1", 1'b0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      logic [31:0] ea;
      string rq;
      ea = 32'h1000_0000 + i * 32'h444;
      rq = $sformatf("R%0d", VECS[i].tag);
      drive(VECS[i].msr, ea, VECS[i].flg);
      @(negedge clk);
      if (VECS[i].kind != 2'd0) begin
        e_srr0 = ea;
        e_srr1 = m_srr1(VECS[i].kind, VECS[i].msr, VECS[i].flg);
        e_msr  = m_msr(VECS[i].msr);
        e_tgt  = VECS[i].tgt;
        chk_all(rq, 1'b1);
      end else begin
        chk_all(rq, 1'b0); // ignored: outputs hold
      end
      drive(32'h0, 32'h0, 5'b0);
      @(negedge clk);
      chk("R11", {31'h0, redir_o}, 32'h0, "redir idle");
      chk("R11", srr0_o, e_srr0, "srr0 hold");
      @(negedge clk);
    end

    // R10 back-to-back faults: second ignored, third taken
    drive(32'h0000_0030, 32'hAAAA_0000, 5'b10000);
    @(negedge clk);
    e_srr0 = 32'hAAAA_0000; e_srr1 = m_srr1(2'd1, 32'h30, 5'b10000);
    e_msr = m_msr(32'h30); e_tgt = 32'h0000_1100;
    chk_all("R10", 1'b1);
    drive(32'h0000_0070, 32'hBBBB_0000, 5'b01000);
    @(negedge clk);
    chk_all("R10", 1'b0);
    @(negedge clk);
    e_srr0 = 32'hBBBB_0000; e_srr1 = m_srr1(2'd3, 32'h70, 5'b01000);
    e_msr = m_msr(32'h70); e_tgt = 32'hFFF0_1200;
    chk_all("R10", 1'b1);
    drive(32'h0, 32'h0, 5'b0);
    @(negedge clk);
    chk("R10", {31'h0, redir_o}, 32'h0, "pulse end");

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    e_srr0 = 0; e_srr1 = 0; e_msr = 0; e_tgt = 0;
    chk_all("R1", 1'b0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule